// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It takes the memory from power-on to a usable state by driving the clock-enable, the command strobes, the bank address and the address lines through the required start-up order. It does not monitor the supplies. A single `power_good` input stands in for that check. The block then counts out the stabilization period with the device quiet, enables the clock, and walks a fixed list of commands. That list holds two precharge-all commands, the three extended mode register loads, a mode register load that resets the DLL, at least two refreshes, a dummy write and a final mode register load that sets the operating mode. Between any two commands it drives NOP for a number of cycles derived from nanosecond parameters.

Every time-based wait is a ceiling division of a nanosecond parameter by the clock period in picoseconds. The rest of the controller stays held off until `init_done` rises. `init_done` then stays high until reset.

Top module: `ddr2_init_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low) the block drives `cke`=0, `cs_n`=1 (deselect) and `init_done`=0, and it sits in its idle state.
- R2: Out of reset the block keeps driving deselect with `cke` low until `power_good` is sampled high. After the sequence has started, `power_good` has no effect on any output.
- R3: The first cycle with `cs_n`=0 starts a span of PWR cycles of NOP with `cke` low. At the end of that span `cke` goes high, and NOP continues for CKE more cycles. Each count is ceil(ns*1000/CLK_PERIOD_PS), with a minimum of 1. NOP is encoded as {cs_n,ras_n,cas_n,we_n}=0111.
- R4: Once `cke` has gone high it stays high until the next reset.
- R5: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as follows: precharge-all is 0010 with addr[10]=1 and all other address bits 0; mode register load is 0000; refresh is 0001; write is 0100. The order is precharge-all, EMR2 load, EMR3 load, EMR1 load, DLL-reset mode load, precharge-all, refreshes, write, operating mode load.
- R6: The EMR2 load uses ba=2 (BA1=1, BA0=0) and addr=EMR2_VAL. The EMR3 load uses ba=3 and addr=EMR3_VAL.
- R7: The EMR1 load uses ba=1 and addr=EMR1_VAL with bit 0 forced to 0 (DLL enabled) and bits 9:7 forced to 0.
- R8: The DLL-reset load uses ba=0 and addr=MR_VAL with bit 8 set. The final operating load uses ba=0 and addr=MR_VAL with bit 8 cleared. The refresh and dummy write use ba=0 and addr=0.
- R9: The distance in cycles from one command to the next depends on the earlier command. It is tRP after a precharge-all, tMRD after an EMR load, the larger of tMRD and DLL_LOCK_CYC after the DLL-reset load, tRFC after a refresh, and WR_GAP_CYC after the write.
- R10: Exactly N_REFRESH refresh commands are issued, and N_REFRESH is at least 2.
- R11: Only NOP is driven between commands. `init_done` rises tMRD cycles after the final mode load and then holds high with `cke` high and NOP on the bus.
- R12: Pulling `rst_n` low in the middle of the sequence drops `cke` and returns the bus to deselect at once. After release, a complete sequence runs again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_good | input | 1 | Supplies and clock are stable |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address lines / mode register payload |
| init_done | output | 1 | Initialization finished, held until reset |

## Verification
The bench runs a small configuration and logs every non-NOP command with its cycle number. It compares each logged command against a schedule worked out from the ceiling-divided gaps. An off-by-one in any wait would shift every later command and be flagged at the first one. The same applies to a missing or extra refresh and to a DLL-reset gap that ignores the lock count.

The mode values are chosen with bit 8 set in MR_VAL and bits 0 and 9:7 set in EMR1_VAL. A design that skipped the forcing of those bits would put wrong payloads on the bus. So would a design that left the DLL-reset bit set in the final load.

`power_good` is dropped partway through one run, which catches a design that restarts or stalls on it. A reset fired after `cke` has risen checks that clock-enable falls immediately and that the next sequence is complete.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    K_DESEL,
    K_NOP,
    K_PREA,
    K_EMR2,
    K_EMR3,
    K_EMR1,
    K_MR_DLLRST,
    K_REF,
    K_WRITE,
    K_MR_OPER
  } cmd_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PWR,
    PH_CKE,
    PH_ISSUE,
    PH_GAP,
    PH_DONE
  } phase_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles covering t_ns at a clock of clk_ps, never below one
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ps);
    return max2(1, (t_ns * 1000 + clk_ps - 1) / clk_ps);
  endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - {{(W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_encode.sv
module init_cmd_encode
  import ddr2_init_pkg::*;
#(
  parameter int unsigned           ADDR_W   = 14,
  parameter int unsigned           BA_W     = 3,
  parameter logic [ADDR_W-1:0]     EMR1_VAL = '0,
  parameter logic [ADDR_W-1:0]     EMR2_VAL = '0,
  parameter logic [ADDR_W-1:0]     EMR3_VAL = '0,
  parameter logic [ADDR_W-1:0]     MR_VAL   = '0
) (
  input  cmd_kind_e         kind,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] A10_BIT   = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] DLLRST_BIT = ADDR_W'(1) << 8;
  // DLL-enable bit 0 and the OCD field 9:7 are forced low
  localparam logic [ADDR_W-1:0] EMR1_CLR  = (ADDR_W'(1) << 0) | (ADDR_W'(7) << 7);
  localparam logic [ADDR_W-1:0] EMR1_WORD = EMR1_VAL & ~EMR1_CLR;
  localparam logic [ADDR_W-1:0] MR_RST    = MR_VAL | DLLRST_BIT;
  localparam logic [ADDR_W-1:0] MR_OPER   = MR_VAL & ~DLLRST_BIT;

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    ba   = '0;
    addr = '0;
    case (kind)
      K_DESEL:     {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      K_NOP:       {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      K_PREA: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0010;
        addr = A10_BIT;
      end
      K_EMR2: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        ba   = BA_W'(2);
        addr = EMR2_VAL;
      end
      K_EMR3: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        ba   = BA_W'(3);
        addr = EMR3_VAL;
      end
      K_EMR1: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        ba   = BA_W'(1);
        addr = EMR1_WORD;
      end
      K_MR_DLLRST: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        addr = MR_RST;
      end
      K_REF:       {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      K_WRITE:     {cs_n, ras_n, cas_n, we_n} = 4'b0100;
      K_MR_OPER: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        addr = MR_OPER;
      end
      default:     {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 14,
  parameter int unsigned       BA_W          = 3,
  parameter int unsigned       CLK_PERIOD_PS = 2500,
  parameter int unsigned       T_PWR_NS      = 200000,
  parameter int unsigned       T_CKE_NS      = 400,
  parameter int unsigned       T_RP_NS       = 15,
  parameter int unsigned       T_MRD_NS      = 5,
  parameter int unsigned       T_RFC_NS      = 128,
  parameter int unsigned       DLL_LOCK_CYC  = 200,
  parameter int unsigned       WR_GAP_CYC    = 16,
  parameter int unsigned       N_REFRESH     = 2,
  parameter logic [ADDR_W-1:0] EMR1_VAL      = '0,
  parameter logic [ADDR_W-1:0] EMR2_VAL      = '0,
  parameter logic [ADDR_W-1:0] EMR3_VAL      = '0,
  parameter logic [ADDR_W-1:0] MR_VAL        = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_good,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int unsigned PWR_C   = ns_to_cycles(T_PWR_NS, CLK_PERIOD_PS);
  localparam int unsigned CKE_C   = ns_to_cycles(T_CKE_NS, CLK_PERIOD_PS);
  localparam int unsigned RP_C    = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
  localparam int unsigned MRD_C   = ns_to_cycles(T_MRD_NS, CLK_PERIOD_PS);
  localparam int unsigned RFC_C   = ns_to_cycles(T_RFC_NS, CLK_PERIOD_PS);
  localparam int unsigned DLL_C   = max2(MRD_C, DLL_LOCK_CYC);
  localparam int unsigned WRG_C   = max2(1, WR_GAP_CYC);
  localparam int unsigned NREF    = max2(2, N_REFRESH);
  localparam int unsigned MAX_C   = max2(max2(max2(PWR_C, CKE_C), max2(RP_C, RFC_C)),
                                         max2(DLL_C, WRG_C));
  localparam int unsigned TMR_W   = $clog2(MAX_C + 1);
  localparam int unsigned N_STEPS = 8 + NREF;
  localparam int unsigned STEP_W  = $clog2(N_STEPS + 1);
  localparam int unsigned WR_STEP = 6 + NREF;
  localparam int unsigned LAST_ST = N_STEPS - 1;

  phase_e            phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              advance;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_expired;
  cmd_kind_e         step_kind;
  logic [TMR_W-1:0]  step_gap;
  cmd_kind_e         bus_kind;

  // step table: command and distance to the next command
  always_comb begin
    step_kind = K_MR_OPER;
    step_gap  = TMR_W'(MRD_C);
    if (step_q == STEP_W'(0)) begin
      step_kind = K_PREA;      step_gap = TMR_W'(RP_C);
    end else if (step_q == STEP_W'(1)) begin
      step_kind = K_EMR2;      step_gap = TMR_W'(MRD_C);
    end else if (step_q == STEP_W'(2)) begin
      step_kind = K_EMR3;      step_gap = TMR_W'(MRD_C);
    end else if (step_q == STEP_W'(3)) begin
      step_kind = K_EMR1;      step_gap = TMR_W'(MRD_C);
    end else if (step_q == STEP_W'(4)) begin
      step_kind = K_MR_DLLRST; step_gap = TMR_W'(DLL_C);
    end else if (step_q == STEP_W'(5)) begin
      step_kind = K_PREA;      step_gap = TMR_W'(RP_C);
    end else if (step_q < STEP_W'(WR_STEP)) begin
      step_kind = K_REF;       step_gap = TMR_W'(RFC_C);
    end else if (step_q == STEP_W'(WR_STEP)) begin
      step_kind = K_WRITE;     step_gap = TMR_W'(WRG_C);
    end
  end

  // next-state logic
  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    step_en  = 1'b0;
    advance  = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (phase_q)
      PH_IDLE: if (power_good) begin
        phase_d  = PH_PWR;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(PWR_C - 1);
      end
      PH_PWR: if (tmr_expired) begin
        phase_d  = PH_CKE;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(CKE_C - 1);
      end
      PH_CKE: if (tmr_expired) begin
        phase_d = PH_ISSUE;
        step_d  = '0;
        step_en = 1'b1;
      end
      PH_ISSUE: begin
        if (step_gap > TMR_W'(1)) begin
          phase_d  = PH_GAP;
          tmr_load = 1'b1;
          tmr_val  = step_gap - TMR_W'(2);
        end else begin
          advance = 1'b1;
        end
      end
      PH_GAP:  advance = tmr_expired;
      PH_DONE: phase_d = PH_DONE;
      default: phase_d = PH_IDLE;
    endcase
    if (advance) begin
      if (step_q == STEP_W'(LAST_ST)) begin
        phase_d = PH_DONE;
      end else begin
        phase_d = PH_ISSUE;
        step_d  = step_q + STEP_W'(1);
        step_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (step_en) step_q <= step_d;
    end
  end

  init_wait_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    case (phase_q)
      PH_IDLE:  bus_kind = K_DESEL;
      PH_ISSUE: bus_kind = step_kind;
      default:  bus_kind = K_NOP;
    endcase
  end

  init_cmd_encode #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .EMR1_VAL (EMR1_VAL),
    .EMR2_VAL (EMR2_VAL),
    .EMR3_VAL (EMR3_VAL),
    .MR_VAL   (MR_VAL)
  ) u_encode (
    .kind  (bus_kind),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr)
  );

  assign cke       = (phase_q != PH_IDLE) && (phase_q != PH_PWR);
  assign init_done = (phase_q == PH_DONE);

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int unsigned ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              power_good,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!cke && cs_n && !init_done));

  assert_start_needs_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(power_good));

  assert_cke_low_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cs_n || (ras_n && cas_n && we_n)));

  assert_cke_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  assert_prea_all_banks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ras_n && cas_n && !we_n) |-> addr[10]);

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && !cs_n && ras_n && cas_n && we_n));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .power_good (power_good),
  .cke        (cke),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .addr       (addr),
  .init_done  (init_done)
);

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;

  localparam int TB_CLK_PERIOD = 10;

  localparam int unsigned P_CLK_PS = 10000;
  localparam int unsigned P_PWR_NS = 2000;
  localparam int unsigned P_CKE_NS = 400;
  localparam int unsigned P_RP_NS  = 15;
  localparam int unsigned P_MRD_NS = 12;
  localparam int unsigned P_RFC_NS = 105;
  localparam int unsigned P_DLL    = 20;
  localparam int unsigned P_WRG    = 4;
  localparam int unsigned P_NREF   = 3;
  localparam logic [13:0] P_EMR1   = 14'h0785;
  localparam logic [13:0] P_EMR2   = 14'h0080;
  localparam logic [13:0] P_EMR3   = 14'h0003;
  localparam logic [13:0] P_MR     = 14'h0532;
  localparam int          NCMD     = 8 + P_NREF;

  logic        clk;
  logic        rst_n;
  logic        power_good;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [2:0]  ba;
  logic [13:0] addr;

  int checks;
  int errors;
  bit finished;

  int          exp_t    [NCMD];
  logic [3:0]  exp_pins [NCMD];
  logic [2:0]  exp_ba   [NCMD];
  logic [13:0] exp_a    [NCMD];
  string       exp_req  [NCMD];
  int          pwr_c, cke_c, done_t;

  ddr2_init_seq #(
    .ADDR_W(14), .BA_W(3), .CLK_PERIOD_PS(P_CLK_PS),
    .T_PWR_NS(P_PWR_NS), .T_CKE_NS(P_CKE_NS), .T_RP_NS(P_RP_NS),
    .T_MRD_NS(P_MRD_NS), .T_RFC_NS(P_RFC_NS), .DLL_LOCK_CYC(P_DLL),
    .WR_GAP_CYC(P_WRG), .N_REFRESH(P_NREF),
    .EMR1_VAL(P_EMR1), .EMR2_VAL(P_EMR2), .EMR3_VAL(P_EMR3), .MR_VAL(P_MR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .power_good(power_good), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  initial clk = 1'b0;
  always #(TB_CLK_PERIOD / 2) clk = ~clk;

  function automatic int cyc(input int unsigned ns);
    int unsigned c;
    c = (ns * 1000 + P_CLK_PS - 1) / P_CLK_PS;
    return (c < 1) ? 1 : int'(c);
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic add_cmd(input int i, input int t, input logic [3:0] pins,
                         input logic [2:0] b, input logic [13:0] a, input string req);
    exp_t[i] = t; exp_pins[i] = pins; exp_ba[i] = b; exp_a[i] = a; exp_req[i] = req;
  endtask

  task automatic build_expected();
    int t;
    int rp, mrd, rfc, dllg;
    pwr_c = cyc(P_PWR_NS);
    cke_c = cyc(P_CKE_NS);
    rp    = cyc(P_RP_NS);
    mrd   = cyc(P_MRD_NS);
    rfc   = cyc(P_RFC_NS);
    dllg  = (P_DLL > mrd) ? P_DLL : mrd;
    t = pwr_c + cke_c;
    add_cmd(0, t, 4'b0010, 3'd0, 14'h0400, "R5 R9 first precharge-all");     t += rp;
    add_cmd(1, t, 4'b0000, 3'd2, P_EMR2, "R6 EMR2 load");                    t += mrd;
    add_cmd(2, t, 4'b0000, 3'd3, P_EMR3, "R6 EMR3 load");                    t += mrd;
    add_cmd(3, t, 4'b0000, 3'd1, P_EMR1 & ~14'h0381, "R7 EMR1 load");        t += mrd;
    add_cmd(4, t, 4'b0000, 3'd0, P_MR | 14'h0100, "R8 DLL-reset load");      t += dllg;
    add_cmd(5, t, 4'b0010, 3'd0, 14'h0400, "R9 second precharge-all");       t += rp;
    for (int k = 0; k < P_NREF; k++) begin
      add_cmd(6 + k, t, 4'b0001, 3'd0, 14'h0000, "R10 refresh");
      t += rfc;
    end
    add_cmd(6 + P_NREF, t, 4'b0100, 3'd0, 14'h0000, "R8 dummy write");       t += P_WRG;
    add_cmd(7 + P_NREF, t, 4'b0000, 3'd0, P_MR & ~14'h0100, "R8 operating load");
    done_t = t + mrd;
  endtask

  task automatic run_sequence(input bit drop_pg);
    int idx, cke_bad, done_bad, nop_bad, guard;
    bit is_cmd;
    idx = 0; cke_bad = 0; done_bad = 0; nop_bad = 0; guard = 0;
    while (cs_n !== 1'b0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check(cs_n === 1'b0, "R3 sequence start", $sformatf("%b", cs_n), "0");
    for (int t = 0; t <= done_t + 4; t++) begin
      if (drop_pg && t == 10) power_good = 1'b0;
      if (cke !== (t >= pwr_c)) cke_bad++;
      if (init_done !== (t >= done_t)) done_bad++;
      if (cs_n !== 1'b0) nop_bad++;
      is_cmd = !(ras_n && cas_n && we_n);
      if (is_cmd || (idx < NCMD && t == exp_t[idx])) begin
        if (idx < NCMD) begin
          check(is_cmd && t == exp_t[idx] &&
                {cs_n, ras_n, cas_n, we_n} == exp_pins[idx] &&
                ba == exp_ba[idx] && addr == exp_a[idx], exp_req[idx],
                $sformatf("t=%0d pins=%b ba=%0d a=%h", t, {cs_n, ras_n, cas_n, we_n}, ba, addr),
                $sformatf("t=%0d pins=%b ba=%0d a=%h", exp_t[idx], exp_pins[idx],
                          exp_ba[idx], exp_a[idx]));
          idx++;
        end else begin
          check(1'b0, "R11 extra command", $sformatf("t=%0d", t), "none");
        end
      end
      @(negedge clk);
    end
    check(idx == NCMD, "R10 command count", $sformatf("%0d", idx), $sformatf("%0d", NCMD));
    check(cke_bad == 0, "R3 R4 cke timing", $sformatf("%0d bad", cke_bad), "0 bad");
    check(done_bad == 0, "R11 init_done timing", $sformatf("%0d bad", done_bad), "0 bad");
    check(nop_bad == 0, "R11 NOP between commands", $sformatf("%0d bad", nop_bad), "0 bad");
    if (drop_pg) begin
      check(idx == NCMD && init_done === 1'b1, "R2 power_good drop ignored",
            $sformatf("%0d/%b", idx, init_done), $sformatf("%0d/1", NCMD));
      power_good = 1'b1;
    end
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; power_good = 1'b0;
    build_expected();
    repeat (3) @(negedge clk);
    check(cke === 1'b0 && cs_n === 1'b1 && init_done === 1'b0, "R1 reset state",
          $sformatf("%b%b%b", cke, cs_n, init_done), "010");
    rst_n = 1'b1;
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (cke !== 1'b0 || cs_n !== 1'b1) bad++;
      end
      check(bad == 0, "R2 idle until power_good", $sformatf("%0d bad", bad), "0 bad");
    end
    power_good = 1'b1;
    run_sequence(1'b1);
    repeat (50) @(negedge clk);
    check(init_done === 1'b1 && cke === 1'b1, "R11 done held",
          $sformatf("%b%b", init_done, cke), "11");
    rst_n = 1'b0;
    #1;
    check(cke === 1'b0 && cs_n === 1'b1 && init_done === 1'b0, "R1 reset after done",
          $sformatf("%b%b%b", cke, cs_n, init_done), "010");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (260) @(negedge clk);
    check(cke === 1'b1, "R12 cke high before mid reset", $sformatf("%b", cke), "1");
    rst_n = 1'b0;
    #1;
    check(cke === 1'b0 && cs_n === 1'b1 && init_done === 1'b0, "R12 mid-sequence reset",
          $sformatf("%b%b%b", cke, cs_n, init_done), "010");
    @(negedge clk);
    rst_n = 1'b1;
    run_sequence(1'b0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule